// File: doc/BRIEF.md
# Ultra DMA Write-Burst Opening Sequencer

This block is the host-side controller that opens an Ultra DMA write burst toward a storage device. It waits for the device's DMA request while the host has write data ready. It then places the task-file address and chip selects at their burst values, lowers the acknowledge, and negates STOP once the envelope time has passed. Next it waits for the device to signal that it is ready, turns on the data bus with the first word, and makes the first falling transition of the host strobe. After the hold time it reports that the first word is out. Steady-state streaming, pausing, termination and CRC are handled by other logic.

Every delay is a whole number of clock cycles. The cycle counts come from a timing table built at elaboration from nanosecond limits and a clock-period parameter in picoseconds. Each minimum is rounded up. Each maximum is rounded down, with a floor of one cycle. A 3-bit mode input selects the row. The mode is captured when a burst is launched.

Top module: `ua_burst_init`

## Requirements
- R1: After synchronous reset, and while idle, the outputs are dmack_n=1, stop=1, hstrobe=1, dd_oe=0, first_word_done=0, err=0, with tf_addr at ADDR_IDLE. tf_addr is {cs1_n, cs0_n, da[2:0]}; by default ADDR_IDLE=5'b11111 and ADDR_BURST=5'b11000. A burst starts when start=1, dmarq=1 and mode<=5.
- R2: A mode value of 6 or 7 does not start a burst. dmack_n stays 1 and tf_addr stays at ADDR_IDLE.
- R3: Without dmarq no burst starts, and ddmardy_n has no effect while idle: dmack_n=1 and dd_oe=0.
- R4: tf_addr equals ADDR_BURST, with stop=1 and hstrobe=1, for at least ceil(20 ns / clock) cycles before dmack_n falls.
- R5: stop falls at least ceil(20 ns) cycles after dmack_n falls. It falls no later than floor(tENV max) cycles after, where tENV max is 70 ns for modes 0–2, 55 ns for modes 3–4 and 50 ns for mode 5.
- R6: dd_oe rises only after the device has asserted ddmardy_n=0 following the negation of stop.
- R7: hstrobe falls at least max(ceil(tDZFS), ceil(tDVS)) cycles after dd_oe rises. dd_out carries the wdata value captured at ready. tDZFS is 70/48/31/20/6.7/25 ns and tDVS is 70/48/31/20/6.7/4.8 ns for modes 0–5.
- R8: first_word_done rises at least ceil(tDVH) cycles after hstrobe falls, with dd_out unchanged. tDVH is 6.2 ns in modes 0–4 and 4.8 ns in mode 5. first_word_done stays high until start returns to 0.
- R9: If ready does not arrive within floor(tLI max)+MARGIN cycles after stop falls, err rises, dmack_n returns to 1 and the bus is never driven. tLI max is 150/100/75 ns for modes 0–2, 3–4 and 5. A ready arriving within floor(tLI max) cycles is accepted.
- R10: After dmack_n rises, tf_addr stays at ADDR_BURST for at least ceil(20 ns) cycles, and dd_oe stays at its value for the same time. Then tf_addr returns to ADDR_IDLE and dd_oe=0.
- R11: err stays set after a timeout and clears when the next burst is launched, by the time dmack_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Host has write data ready; drop to close after first word |
| mode | input | 3 | Timing mode 0–5 |
| wdata | input | DATA_W | First write word |
| dmarq | input | 1 | Device DMA request |
| ddmardy_n | input | 1 | Device ready, active low |
| dmack_n | output | 1 | Host acknowledge, active low |
| stop | output | 1 | Host STOP line |
| hstrobe | output | 1 | Host strobe |
| dd_out | output | DATA_W | Data bus value |
| dd_oe | output | 1 | Data bus drive enable |
| tf_addr | output | 5 | {cs1_n, cs0_n, da[2:0]} |
| first_word_done | output | 1 | First strobe edge made and hold time met |
| err | output | 1 | Ready timeout occurred |

## Verification
A wrong phase state or a wrong dwell count shows up at the ports within one burst. It appears as a shifted edge on dmack_n, stop, dd_oe or hstrobe, and so as a gap between two of those edges that falls outside its window. A mode row taken from the wrong index breaks the lead or hold spacing only in some modes, so every mode is swept with several device response delays. A broken timeout counter either raises err while the device is still inside its interlock window, or never leaves the wait. The timeout bursts and the maximum-delay bursts catch both cases.

// File: rtl/ua_burst_pkg.sv
package ua_burst_pkg;
    localparam int NUM_MODES = 6;
    localparam int CNT_W     = 8;
    localparam int ACK_PS    = 20000;
    localparam int ENV_MIN_PS = 20000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_ACK, ST_WAIT, ST_DRIVE, ST_STROBE, ST_DONE, ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] ack;    // address setup and release hold
        logic [CNT_W-1:0] env;    // acknowledge to STOP negation
        logic [CNT_W-1:0] lead;   // bus turn-on to first strobe edge
        logic [CNT_W-1:0] hold;   // data hold after strobe edge
        logic [CNT_W-1:0] limit;  // ready wait before timeout
    } phase_cyc_t;

    function automatic int dzfs_ps(input int m);
        case (m)
            0: return 70000;  1: return 48000;  2: return 31000;
            3: return 20000;  4: return 6700;   default: return 25000;
        endcase
    endfunction

    function automatic int dvs_ps(input int m);
        case (m)
            0: return 70000;  1: return 48000;  2: return 31000;
            3: return 20000;  4: return 6700;   default: return 4800;
        endcase
    endfunction

    function automatic int dvh_ps(input int m);
        return (m == 5) ? 4800 : 6200;
    endfunction

    function automatic int li_max_ps(input int m);
        return (m <= 2) ? 150000 : ((m <= 4) ? 100000 : 75000);
    endfunction

    function automatic int cyc_up(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int cyc_down(input int ps, input int clk_ps);
        int c;
        c = ps / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ua_burst_timing.sv
module ua_burst_timing
    import ua_burst_pkg::*;
#(
    parameter int CLK_PS = 10000,
    parameter int MARGIN = 4
) (
    input  logic [2:0] mode_sel,
    output phase_cyc_t cyc
);
    phase_cyc_t tbl [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_row
        assign tbl[g].ack   = CNT_W'(cyc_up(ACK_PS, CLK_PS));
        assign tbl[g].env   = CNT_W'(cyc_up(ENV_MIN_PS, CLK_PS));
        assign tbl[g].lead  = CNT_W'(max2(cyc_up(dzfs_ps(g), CLK_PS),
                                          cyc_up(dvs_ps(g), CLK_PS)));
        assign tbl[g].hold  = CNT_W'(cyc_up(dvh_ps(g), CLK_PS));
        assign tbl[g].limit = CNT_W'(cyc_down(li_max_ps(g), CLK_PS) + MARGIN);
    end

    assign cyc = (int'(mode_sel) < NUM_MODES) ? tbl[mode_sel] : tbl[0];
endmodule

// File: rtl/ua_burst_seq.sv
module ua_burst_seq
    import ua_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dmarq,
    input  logic       ddmardy_n,
    input  logic [2:0] mode,
    input  phase_cyc_t cyc,
    output seq_state_e state,
    output logic [2:0] mode_q,
    output logic       err,
    output logic       load_word
);
    seq_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             timeout;
    logic             launch;

    function automatic logic [CNT_W-1:0] dwell(input seq_state_e s, input phase_cyc_t c);
        case (s)
            ST_SETUP, ST_RELEASE: return c.ack;
            ST_ACK:               return c.env;
            ST_WAIT:              return c.limit;
            ST_DRIVE:             return c.lead;
            ST_STROBE:            return c.hold;
            default:              return CNT_W'(1);
        endcase
    endfunction

    always_comb begin
        nxt       = state;
        load_word = 1'b0;
        timeout   = 1'b0;
        launch    = 1'b0;
        case (state)
            ST_IDLE:
                if (start && dmarq && (int'(mode) < NUM_MODES)) begin
                    nxt    = ST_SETUP;
                    launch = 1'b1;
                end
            ST_SETUP:  if (cnt == '0) nxt = ST_ACK;
            ST_ACK:    if (cnt == '0) nxt = ST_WAIT;
            ST_WAIT:
                if (!ddmardy_n) begin
                    nxt       = ST_DRIVE;
                    load_word = 1'b1;
                end else if (cnt == '0) begin
                    nxt     = ST_RELEASE;
                    timeout = 1'b1;
                end
            ST_DRIVE:   if (cnt == '0) nxt = ST_STROBE;
            ST_STROBE:  if (cnt == '0) nxt = ST_DONE;
            ST_DONE:    if (!start) nxt = ST_RELEASE;
            ST_RELEASE: if (cnt == '0) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= '0;
            err    <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= dwell(nxt, cyc) - CNT_W'(1);
            else if (cnt != '0)
                cnt <= cnt - CNT_W'(1);
            if (launch) begin
                mode_q <= mode;
                err    <= 1'b0;
            end else if (timeout) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ua_burst_drive.sv
module ua_burst_drive
    import ua_burst_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter logic [4:0]  ADDR_BURST = 5'b11000,
    parameter logic [4:0]  ADDR_IDLE  = 5'b11111
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              load_word,
    input  logic [DATA_W-1:0] wdata,
    output logic              dmack_n,
    output logic              stop,
    output logic              hstrobe,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [4:0]        tf_addr,
    output logic              first_word_done
);
    logic [DATA_W-1:0] word_q;
    logic              data_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            data_on <= 1'b0;
        end else begin
            if (load_word) begin
                word_q  <= wdata;
                data_on <= 1'b1;
            end else if (state == ST_IDLE) begin
                data_on <= 1'b0;
            end
        end
    end

    always_comb begin
        dmack_n = !(state inside {ST_ACK, ST_WAIT, ST_DRIVE, ST_STROBE, ST_DONE});
        stop    = !(state inside {ST_WAIT, ST_DRIVE, ST_STROBE, ST_DONE});
        hstrobe = !(state inside {ST_STROBE, ST_DONE});
        dd_oe   = data_on && (state inside {ST_DRIVE, ST_STROBE, ST_DONE, ST_RELEASE});
        dd_out  = dd_oe ? word_q : '0;
        tf_addr = (state == ST_IDLE) ? ADDR_IDLE : ADDR_BURST;
        first_word_done = (state == ST_DONE);
    end
endmodule

// File: rtl/ua_burst_init.sv
module ua_burst_init
    import ua_burst_pkg::*;
#(
    parameter int         CLK_PS     = 10000,
    parameter int         DATA_W     = 16,
    parameter int         MARGIN     = 4,
    parameter logic [4:0] ADDR_BURST = 5'b11000,
    parameter logic [4:0] ADDR_IDLE  = 5'b11111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dmarq,
    input  logic              ddmardy_n,
    output logic              dmack_n,
    output logic              stop,
    output logic              hstrobe,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [4:0]        tf_addr,
    output logic              first_word_done,
    output logic              err
);
    phase_cyc_t cyc;
    seq_state_e state;
    logic [2:0] mode_q;
    logic       load_word;

    ua_burst_timing #(.CLK_PS(CLK_PS), .MARGIN(MARGIN)) u_timing (
        .mode_sel (mode_q),
        .cyc      (cyc)
    );

    ua_burst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dmarq     (dmarq),
        .ddmardy_n (ddmardy_n),
        .mode      (mode),
        .cyc       (cyc),
        .state     (state),
        .mode_q    (mode_q),
        .err       (err),
        .load_word (load_word)
    );

    ua_burst_drive #(.DATA_W(DATA_W), .ADDR_BURST(ADDR_BURST), .ADDR_IDLE(ADDR_IDLE)) u_drive (
        .clk             (clk),
        .rst             (rst),
        .state           (state),
        .load_word       (load_word),
        .wdata           (wdata),
        .dmack_n         (dmack_n),
        .stop            (stop),
        .hstrobe         (hstrobe),
        .dd_out          (dd_out),
        .dd_oe           (dd_oe),
        .tf_addr         (tf_addr),
        .first_word_done (first_word_done)
    );
endmodule

// File: rtl/ua_burst_init_chk.sv
module ua_burst_init_chk #(
    parameter int         DATA_W     = 16,
    parameter logic [4:0] ADDR_BURST = 5'b11000,
    parameter logic [4:0] ADDR_IDLE  = 5'b11111
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode,
    input logic              dmarq,
    input logic              ddmardy_n,
    input logic              dmack_n,
    input logic              stop,
    input logic              hstrobe,
    input logic [DATA_W-1:0] dd_out,
    input logic              dd_oe,
    input logic [4:0]        tf_addr,
    input logic              first_word_done,
    input logic              err
);
    assert_addr_before_ack_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dmack_n) |-> ($past(tf_addr) == ADDR_BURST) && stop && hstrobe);

    assert_stop_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(stop) |-> !dmack_n && !$past(dmack_n));

    assert_oe_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dd_oe) |-> !stop && !$past(ddmardy_n));

    assert_strobe_data_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hstrobe) |-> dd_oe && $past(dd_oe) && $stable(dd_out));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(first_word_done) |-> !hstrobe && $stable(dd_out));

    assert_timeout_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> dmack_n && !dd_oe);

    assert_release_addr_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(dmack_n) |-> tf_addr == ADDR_BURST);

    assert_bad_mode_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (tf_addr == ADDR_IDLE && mode > 3'd5) |=> tf_addr == ADDR_IDLE);

    assert_no_request_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (tf_addr == ADDR_IDLE && !dmarq) |=> tf_addr == ADDR_IDLE && dmack_n);
endmodule

bind ua_burst_init ua_burst_init_chk #(
    .DATA_W(DATA_W), .ADDR_BURST(ADDR_BURST), .ADDR_IDLE(ADDR_IDLE)
) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .dmarq(dmarq), .ddmardy_n(ddmardy_n),
    .dmack_n(dmack_n), .stop(stop), .hstrobe(hstrobe), .dd_out(dd_out),
    .dd_oe(dd_oe), .tf_addr(tf_addr), .first_word_done(first_word_done), .err(err)
);

// File: tb/ua_burst_init_tb.sv
`timescale 1ns/1ps
module ua_burst_init_tb;
    localparam int         CLK_PS = 5000;
    localparam int         MARGIN = 4;
    localparam logic [4:0] A_BURST = 5'b11000;
    localparam logic [4:0] A_IDLE  = 5'b11111;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, dmarq = 1'b0, ddmardy_n = 1'b1;
    logic [2:0]  mode = '0;
    logic [15:0] wdata = '0;
    logic        dmack_n, stop, hstrobe, dd_oe, first_word_done, err;
    logic [15:0] dd_out;
    logic [4:0]  tf_addr;

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ua_burst_init #(.CLK_PS(CLK_PS), .MARGIN(MARGIN), .ADDR_BURST(A_BURST), .ADDR_IDLE(A_IDLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .wdata(wdata), .dmarq(dmarq),
        .ddmardy_n(ddmardy_n), .dmack_n(dmack_n), .stop(stop), .hstrobe(hstrobe),
        .dd_out(dd_out), .dd_oe(dd_oe), .tf_addr(tf_addr),
        .first_word_done(first_word_done), .err(err)
    );

    function automatic int up(input int ps);
        int c; c = (ps + CLK_PS - 1) / CLK_PS; return (c < 1) ? 1 : c;
    endfunction
    function automatic int dn(input int ps);
        int c; c = ps / CLK_PS; return (c < 1) ? 1 : c;
    endfunction
    function automatic int e_dzfs(input int m);
        int t [6] = '{70000, 48000, 31000, 20000, 6700, 25000}; return up(t[m]);
    endfunction
    function automatic int e_dvs(input int m);
        int t [6] = '{70000, 48000, 31000, 20000, 6700, 4800}; return up(t[m]);
    endfunction
    function automatic int e_dvh(input int m);
        return up(m == 5 ? 4800 : 6200);
    endfunction
    function automatic int e_envmax(input int m);
        return dn(m <= 2 ? 70000 : (m <= 4 ? 55000 : 50000));
    endfunction
    function automatic int e_li(input int m);
        return dn(m <= 2 ? 150000 : (m <= 4 ? 100000 : 75000));
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic stay_idle(input string req, input logic [2:0] m, input logic rq, input logic rdy);
        int bad = 0;
        @(negedge clk);
        mode = m; dmarq = rq; ddmardy_n = rdy; start = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!dmack_n || dd_oe || tf_addr != A_IDLE) bad++;
        end
        chk(bad == 0, req, "cycles leaving idle", bad, 0);
        start = 1'b0; dmarq = 1'b0; ddmardy_n = 1'b1; mode = '0;
        @(negedge clk);
    endtask

    task automatic run_burst(input int m, input int dly, input bit to);
        int cyc = 0;
        int t_da = -1, t_ack = -1, t_stop = -1, t_rdy = -1, t_oe = -1, t_hs = -1;
        int t_fwd = -1, t_rel = -1, t_off = -1, t_err = -1;
        int init_bad = 0, data_bad = 0, err_at_ack = 0;
        logic [15:0] wd;
        wd = 16'hA5C0 ^ 16'(m << 8) ^ 16'(dly);
        @(negedge clk);
        mode = 3'(m); wdata = wd; dmarq = 1'b1; ddmardy_n = 1'b1; start = 1'b1;
        while (t_off < 0 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (t_da < 0 && tf_addr == A_BURST) t_da = cyc;
            if (t_da >= 0 && t_ack < 0 && dmack_n && !(stop && hstrobe)) init_bad++;
            if (t_ack < 0 && !dmack_n) begin t_ack = cyc; err_at_ack = int'(err); end
            if (t_ack >= 0 && t_stop < 0 && !stop) t_stop = cyc;
            if (!to && t_stop >= 0 && t_rdy < 0 && cyc == t_stop + dly) begin
                ddmardy_n = 1'b0; t_rdy = cyc;
            end
            if (t_oe < 0 && dd_oe) t_oe = cyc;
            if (t_oe >= 0 && t_fwd < 0 && dd_out != wd) data_bad++;
            if (t_ack >= 0 && t_hs < 0 && !hstrobe) t_hs = cyc;
            if (t_fwd < 0 && first_word_done) begin
                t_fwd = cyc;
                if (!hstrobe && dd_out == wd) start = 1'b0; else begin start = 1'b0; data_bad++; end
            end
            if (t_err < 0 && err) begin t_err = cyc; start = 1'b0; end
            if (t_ack >= 0 && t_rel < 0 && dmack_n) begin
                t_rel = cyc; ddmardy_n = 1'b1; dmarq = 1'b0;
            end
            if (t_rel >= 0 && t_off < 0 && !dd_oe && tf_addr == A_IDLE) t_off = cyc;
        end
        start = 1'b0; dmarq = 1'b0; ddmardy_n = 1'b1;
        chk(t_off > 0, "R10", "burst reached idle", t_off, 1);
        chk(t_ack - t_da >= up(20000), "R4", "address setup cycles", t_ack - t_da, up(20000));
        chk(init_bad == 0, "R4", "stop/hstrobe not idle before ack", init_bad, 0);
        chk(t_stop - t_ack >= up(20000), "R5", "envelope min", t_stop - t_ack, up(20000));
        chk(t_stop - t_ack <= e_envmax(m), "R5", "envelope max", t_stop - t_ack, e_envmax(m));
        chk(t_off - t_rel >= up(20000), "R10", "release hold", t_off - t_rel, up(20000));
        chk(err_at_ack == 0, "R11", "err at ack", err_at_ack, 0);
        if (to) begin
            chk(t_err > 0 && t_err - t_stop > e_li(m), "R9", "timeout not early", t_err - t_stop, e_li(m) + 1);
            chk(t_err - t_stop <= e_li(m) + MARGIN, "R9", "timeout not late", t_err - t_stop, e_li(m) + MARGIN);
            chk(t_oe < 0, "R9", "bus driven on timeout", t_oe, -1);
            chk(t_rel == t_err, "R9", "ack dropped with err", t_rel, t_err);
        end else begin
            chk(t_err < 0, "R9", "spurious err", t_err, -1);
            chk(t_oe > t_rdy && t_rdy > 0, "R6", "oe after ready", t_oe, t_rdy + 1);
            chk(t_hs - t_oe >= e_dzfs(m), "R7", "bus on to strobe", t_hs - t_oe, e_dzfs(m));
            chk(t_hs - t_oe >= e_dvs(m), "R7", "data setup", t_hs - t_oe, e_dvs(m));
            chk(t_fwd - t_hs >= e_dvh(m), "R8", "data hold", t_fwd - t_hs, e_dvh(m));
            chk(data_bad == 0, "R8", "data changes", data_bad, 0);
            chk(t_rel > t_fwd, "R8", "done held until start low", t_rel, t_fwd + 1);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dmack_n && stop && hstrobe && !dd_oe && !first_word_done && !err && tf_addr == A_IDLE,
            "R1", "reset state", int'({dmack_n, stop, hstrobe, dd_oe, tf_addr}),
            int'({1'b1, 1'b1, 1'b1, 1'b0, A_IDLE}));
        stay_idle("R2", 3'd6, 1'b1, 1'b1);
        stay_idle("R2", 3'd7, 1'b1, 1'b1);
        stay_idle("R3", 3'd2, 1'b0, 1'b0);
        for (int m = 0; m < 6; m++) begin
            run_burst(m, 0, 1'b0);
            run_burst(m, 3, 1'b0);
            run_burst(m, e_li(m), 1'b0);
        end
        for (int m = 0; m < 6; m += 2) begin
            run_burst(m, 0, 1'b1);
            chk(err == 1'b1, "R11", "err held after timeout", int'(err), 1);
            run_burst(5 - m, 1, 1'b0);
            chk(err == 1'b0, "R11", "err cleared by new burst", int'(err), 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule